// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Controller

This block collects level-sensitive interrupt lines and delivers each one to one or more of up to four processors. Software sees it through a small register bus that has a global view and a per-processor view; the `bus_local` input selects the per-processor view and `bus_cpu` names the processor making the access.

Global enables and per-processor masks are never rewritten as whole words. Software writes a source number to a set port or a clear port, and that one bit changes. A routing word for each source holds one bit per processor and decides where the source may go. Each processor reads an acknowledge register that returns the lowest-numbered source it should service.

One source number is reserved for a private per-processor timer. Each processor has its own input line for it, and that line is gated only by that processor's mask. Sources 0 and 1 carry the summaries of the two doorbell units, which sit outside this block, and are otherwise ordinary sources.

Top module: `mcpu_irq_core`

## Requirements
- R1: While reset is asserted and after it is released, every global enable is cleared, every mask bit is set and every routing word selects processor 0 (value 1). As a result, `irq_o` is 0 and every acknowledge read returns 1023, whatever the input lines are doing.
- R2: In the global view, writing source number n to offset 0x30 sets the enable of source n, and writing n to offset 0x34 clears it.
- R3: In the per-processor view, writing n to offset 0x48 masks source n for the processor on `bus_cpu`, and writing n to 0x4C unmasks it. The masks of the other processors do not change.
- R4: The global word at offset 0x100 + 4*n holds the routing of source n in bits [NUM_CPU-1:0], bit c meaning processor c. The word can be written and read back. When several bits are set, the source is delivered to every processor whose bit is set.
- R5: A read of per-processor offset 0x44 returns, in bits [9:0] of the next-cycle `bus_rdata`, the lowest-numbered source that is high, enabled, routed to that processor and unmasked for it. It returns 1023 when no source qualifies.
- R6: A read of global offset 0x00 returns the number of sources in bits [11:2].
- R7: Source 5 is private to each processor. For processor c it is pending when `priv_in[c]` is high and source 5 is unmasked for c. `src_in[5]`, the global enable of source 5 and its routing word have no effect on it.
- R8: A set or clear write whose data is NUM_SRC or larger changes nothing. A routing write at an offset for a source at or beyond NUM_SRC also changes nothing.
- R9: Sources are level-sensitive. Reading the acknowledge register does not clear anything, and a source stops being reported as soon as its line goes low.
- R10: `irq_o[c]` is high exactly when an acknowledge read by processor c would return a value other than 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cpu | input | CPU_W | Processor making the access |
| bus_local | input | 1 | 1 selects the per-processor view, 0 the global view |
| bus_addr | input | 12 | Byte offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; data appears one cycle later |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | NUM_SRC | Global level interrupt lines |
| priv_in | input | NUM_CPU | Private timer line of each processor |
| irq_o | output | NUM_CPU | Interrupt request to each processor |

## Verification
Any internal fault in an enable, mask or routing bit becomes visible at the ports within one cycle. `irq_o` is combinational from that state, and an acknowledge read returns the wrong source number or 1023 in the cycle after the read strobe. Set and clear writes are tested next to sources that share low address bits with out-of-range numbers, so a decoder that truncates the source number shows up as a lost request on source 0. The bench also has per-processor masks that differ between processors, so a mask write that lands on the wrong processor is caught.

// File: rtl/mic_pkg.sv
package mic_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ID_W   = 10;

    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;
    localparam int PRIV_SRC = 5;

    // global view
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h034;
    // per-processor view
    localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_MSK_SET = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_MSK_CLR = 12'h04C;

    typedef enum logic [2:0] {
        OP_IDLE, OP_EN_SET, OP_EN_CLR, OP_MSK_SET, OP_MSK_CLR, OP_ROUTE_WR
    } wr_op_e;

    typedef enum logic [1:0] {
        RD_ZERO, RD_CTRL, RD_ACK, RD_ROUTE
    } rd_sel_e;

    typedef struct packed {
        wr_op_e          op;
        logic [ID_W-1:0] idx;
        logic            idx_ok;
    } wr_cmd_t;

    function automatic logic is_route_ofs(input logic [ADDR_W-1:0] a);
        return (a[11:8] == 4'h1) && (a[1:0] == 2'b00);
    endfunction

    function automatic wr_op_e decode_wr(input logic loc, input logic [ADDR_W-1:0] a);
        if (loc) begin
            if (a == OFS_MSK_SET) return OP_MSK_SET;
            if (a == OFS_MSK_CLR) return OP_MSK_CLR;
        end else begin
            if (a == OFS_EN_SET) return OP_EN_SET;
            if (a == OFS_EN_CLR) return OP_EN_CLR;
            if (is_route_ofs(a)) return OP_ROUTE_WR;
        end
        return OP_IDLE;
    endfunction

    function automatic rd_sel_e decode_rd(input logic loc, input logic [ADDR_W-1:0] a);
        if (loc) begin
            if (a == OFS_ACK) return RD_ACK;
        end else begin
            if (a == OFS_CTRL) return RD_CTRL;
            if (is_route_ofs(a)) return RD_ROUTE;
        end
        return RD_ZERO;
    endfunction
endpackage

// File: rtl/mic_decode.sv
module mic_decode
    import mic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic              we,
    input  logic              loc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wr_cmd_t           cmd,
    output rd_sel_e           rsel,
    output logic [ID_W-1:0]   ridx
);
    localparam int HI_W = DATA_W - ID_W;

    wr_op_e          op;
    logic [ID_W-1:0] route_idx;
    logic [ID_W-1:0] num_idx;
    logic            num_ok;

    always_comb begin
        op        = we ? decode_wr(loc, addr) : OP_IDLE;
        route_idx = {{(ID_W-6){1'b0}}, addr[7:2]};
        num_idx   = wdata[ID_W-1:0];
        num_ok    = (wdata[DATA_W-1:ID_W] == HI_W'(0)) && (num_idx < ID_W'(NUM_SRC));

        cmd.op = op;
        if (op == OP_ROUTE_WR) begin
            cmd.idx    = route_idx;
            cmd.idx_ok = route_idx < ID_W'(NUM_SRC);
        end else begin
            cmd.idx    = num_idx;
            cmd.idx_ok = num_ok;
        end

        rsel = decode_rd(loc, addr);
        ridx = route_idx;
    end
endmodule

// File: rtl/mic_regs.sv
module mic_regs
    import mic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  wr_cmd_t                          cmd,
    input  logic [CPU_W-1:0]                 cpu_sel,
    input  logic [NUM_CPU-1:0]               route_data,
    output logic [NUM_SRC-1:0]               en_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]  msk_q,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]  route_q
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic hit;
        assign hit = cmd.idx_ok && (cmd.idx == ID_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[s] <= 1'b0;
            end else if (hit && cmd.op == OP_EN_SET) begin
                en_q[s] <= 1'b1;
            end else if (hit && cmd.op == OP_EN_CLR) begin
                en_q[s] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                route_q[s] <= NUM_CPU'(1);
            end else if (hit && cmd.op == OP_ROUTE_WR) begin
                route_q[s] <= route_data;
            end
        end

        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            logic mine;
            assign mine = hit && (cpu_sel == CPU_W'(c));

            always_ff @(posedge clk) begin
                if (rst) begin
                    msk_q[c][s] <= 1'b1;
                end else if (mine && cmd.op == OP_MSK_SET) begin
                    msk_q[c][s] <= 1'b1;
                end else if (mine && cmd.op == OP_MSK_CLR) begin
                    msk_q[c][s] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mic_pick.sv
module mic_pick
    import mic_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]    vec,
    output logic            found,
    output logic [ID_W-1:0] idx
);
    // lowest index wins: scan downwards so the last hit is the smallest
    always_comb begin
        found = 1'b0;
        idx   = ID_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/mcpu_irq_core.sv
module mcpu_irq_core
    import mic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic               bus_local,
    input  logic [11:0]        bus_addr,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_CPU-1:0] priv_in,
    output logic [NUM_CPU-1:0] irq_o
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    wr_cmd_t                            cmd;
    rd_sel_e                            rsel;
    logic [ID_W-1:0]                    ridx;
    logic [NUM_SRC-1:0]                 en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]    msk_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]    route_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]    qual;
    logic [NUM_CPU-1:0][ID_W-1:0]       ack_id;
    logic                               unused_priv_line;

    assign unused_priv_line = src_in[PRIV_SRC];

    mic_decode #(.NUM_SRC(NUM_SRC)) dec_i (
        .we    (bus_we),
        .loc   (bus_local),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd   (cmd),
        .rsel  (rsel),
        .ridx  (ridx)
    );

    mic_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .cpu_sel    (bus_cpu),
        .route_data (bus_wdata[NUM_CPU-1:0]),
        .en_q       (en_q),
        .msk_q      (msk_q),
        .route_q    (route_q)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            if (s == PRIV_SRC) begin : g_priv
                assign qual[c][s] = priv_in[c] & ~msk_q[c][s];
            end else begin : g_glob
                assign qual[c][s] = src_in[s] & en_q[s] & route_q[s][c] & ~msk_q[c][s];
            end
        end

        mic_pick #(.N(NUM_SRC)) pick_i (
            .vec   (qual[c]),
            .found (irq_o[c]),
            .idx   (ack_id[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            unique case (rsel)
                RD_CTRL:  bus_rdata <= {20'b0, ID_W'(NUM_SRC), 2'b00};
                RD_ACK:   bus_rdata <= {22'b0, ack_id[bus_cpu]};
                RD_ROUTE: bus_rdata <= (ridx < ID_W'(NUM_SRC))
                                     ? DATA_W'(route_q[ridx[SRC_W-1:0]]) : '0;
                default:  bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/mic_checker.sv
module mic_checker
    import mic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input logic                            clk,
    input logic                            rst,
    input logic [CPU_W-1:0]                bus_cpu,
    input logic                            bus_local,
    input logic [11:0]                     bus_addr,
    input logic                            bus_we,
    input logic                            bus_re,
    input logic [31:0]                     bus_wdata,
    input logic [31:0]                     bus_rdata,
    input logic [NUM_SRC-1:0]              src_in,
    input logic [NUM_CPU-1:0]              priv_in,
    input logic [NUM_CPU-1:0]              irq_o,
    input logic [NUM_SRC-1:0]              en_q,
    input logic [NUM_CPU-1:0][NUM_SRC-1:0] msk_q
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic ack_rd, ctrl_rd, en_clr_wr, msk_set_wr;
    assign ack_rd     = bus_re && bus_local && bus_addr == OFS_ACK;
    assign ctrl_rd    = bus_re && !bus_local && bus_addr == OFS_CTRL;
    assign en_clr_wr  = bus_we && !bus_local && bus_addr == OFS_EN_CLR && bus_wdata < NUM_SRC;
    assign msk_set_wr = bus_we && bus_local && bus_addr == OFS_MSK_SET && bus_wdata < NUM_SRC;

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> irq_o == '0);

    a_r2_enable_cleared: assert property (@(posedge clk) disable iff (rst)
        en_clr_wr |=> !en_q[$past(bus_wdata[SRC_W-1:0])]);

    a_r3_mask_set: assert property (@(posedge clk) disable iff (rst)
        msk_set_wr |=> msk_q[$past(bus_cpu)][$past(bus_wdata[SRC_W-1:0])]);

    a_r5_ack_in_range: assert property (@(posedge clk) disable iff (rst)
        ack_rd |=> (bus_rdata[9:0] == 10'd1023 || bus_rdata[9:0] < NUM_SRC));

    a_r6_count_field: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd |=> bus_rdata[11:2] == 10'(NUM_SRC));

    a_r10_irq_matches_ack: assert property (@(posedge clk) disable iff (rst)
        ack_rd |=> ((bus_rdata[9:0] != 10'd1023) == $past(irq_o[bus_cpu])));

    a_r9_needs_a_line: assert property (@(posedge clk) disable iff (rst)
        (irq_o != '0) |-> (src_in != '0 || priv_in != '0));
endmodule

bind mcpu_irq_core mic_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_cpu   (bus_cpu),
    .bus_local (bus_local),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .priv_in   (priv_in),
    .irq_o     (irq_o),
    .en_q      (en_q),
    .msk_q     (msk_q)
);

// File: tb/mcpu_irq_core_tb_top.sv
module mcpu_irq_core_tb_top;
    localparam int NS = 32;
    localparam int NC = 4;
    localparam logic [9:0] NONE = 10'd1023;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_cpu = '0;
    logic        bus_local = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] src_in = '0;
    logic [NC-1:0] priv_in = '0;
    logic [NC-1:0] irq_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    mcpu_irq_core #(.NUM_SRC(NS), .NUM_CPU(NC)) dut_i (
        .clk (clk), .rst (rst), .bus_cpu (bus_cpu), .bus_local (bus_local),
        .bus_addr (bus_addr), .bus_we (bus_we), .bus_re (bus_re),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .src_in (src_in), .priv_in (priv_in), .irq_o (irq_o)
    );

    // {src_in, priv_in, ack cpu0, ack cpu1, ack cpu2, ack cpu3}
    // configuration: all enabled, source n routed to cpu n%4, all unmasked
    // except source 9 on cpu1 and source 5 on cpu2
    localparam logic [75:0] VEC [8] = '{
        {32'h0000_0000, 4'h0, 10'd1023, 10'd1023, 10'd1023, 10'd1023},
        {32'h0000_0003, 4'h0, 10'd0,    10'd1,    10'd1023, 10'd1023},
        {32'h0000_0F00, 4'h0, 10'd8,    10'd1023, 10'd10,   10'd11},
        {32'h0000_0020, 4'h0, 10'd1023, 10'd1023, 10'd1023, 10'd1023},
        {32'h0000_0000, 4'hF, 10'd5,    10'd5,    10'd1023, 10'd5},
        {32'h8000_0010, 4'h1, 10'd4,    10'd1023, 10'd1023, 10'd31},
        {32'hFFFF_FFFF, 4'h0, 10'd0,    10'd1,    10'd2,    10'd3},
        {32'hFFFF_FFF0, 4'h4, 10'd4,    10'd13,   10'd6,    10'd7}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] c, input logic l, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cpu = c; bus_local = l; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] c, input logic l, input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_cpu = c; bus_local = l; bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic ack_is(input string tag, input logic [1:0] c, input logic [9:0] exp);
        logic [31:0] v;
        rd(c, 1'b1, 12'h044, v);
        chk(tag, v, {22'b0, exp});
    endtask

    task automatic lines(input logic [31:0] s, input logic [3:0] p);
        @(negedge clk);
        src_in = s; priv_in = p;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        src_in = '1; priv_in = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything masked and disabled
        @(negedge clk);
        chk("R1 irq after reset", 32'(irq_o), 32'd0);
        for (int c = 0; c < NC; c++) ack_is("R1 ack after reset", 2'(c), NONE);
        rd(0, 1'b0, 12'h100, v);
        chk("R1 route reset", v, 32'd1);

        // R6
        rd(0, 1'b0, 12'h000, v);
        chk("R6 source count", 32'(v[11:2]), 32'(NS));

        lines('0, '0);
        for (int s = 0; s < NS; s++) wr(0, 1'b0, 12'h030, 32'(s));
        for (int s = 0; s < NS; s++) wr(0, 1'b0, 12'(12'h100 + 4 * s), 32'(1 << (s % 4)));
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++)
                if (!(c == 1 && s == 9) && !(c == 2 && s == 5))
                    wr(2'(c), 1'b1, 12'h04C, 32'(s));

        // R4 readback
        rd(0, 1'b0, 12'h11C, v);
        chk("R4 route readback", v, 32'd8);

        // R5 / R7 / R10 vector walk
        for (int i = 0; i < 8; i++) begin
            lines(VEC[i][75:44], VEC[i][43:40]);
            for (int c = 0; c < NC; c++) begin
                logic [9:0] e;
                e = VEC[i][10*(3-c) +: 10];
                ack_is("R5 R7 table ack", 2'(c), e);
                chk("R10 irq vs ack", 32'(irq_o[c]), 32'(e != NONE));
            end
        end

        // R2 enable set/clear
        lines(32'h0000_0100, 4'h0);
        ack_is("R2 enabled", 0, 10'd8);
        wr(0, 1'b0, 12'h034, 32'd8);
        ack_is("R2 cleared", 0, NONE);
        wr(0, 1'b0, 12'h030, 32'd8);
        ack_is("R2 set again", 0, 10'd8);

        // R7 private source ignores enable and route
        lines(32'h0, 4'h1);
        wr(0, 1'b0, 12'h034, 32'd5);
        wr(0, 1'b0, 12'h114, 32'd2);
        ack_is("R7 enable ignored", 0, 10'd5);
        ack_is("R7 route ignored", 1, NONE);
        wr(0, 1'b0, 12'h030, 32'd5);

        // R8 out-of-range numbers
        lines(32'h0000_0001, 4'h0);
        wr(0, 1'b0, 12'h034, 32'd32);
        wr(0, 1'b1, 12'h048, 32'd32);
        wr(0, 1'b0, 12'h034, 32'h0001_0000);
        wr(0, 1'b0, 12'h180, 32'd2);
        ack_is("R8 source 0 untouched", 0, 10'd0);
        rd(0, 1'b0, 12'h100, v);
        chk("R8 route 0 untouched", v, 32'd1);

        // R3 mask per processor
        lines(32'h0000_1000, 4'h0);
        wr(0, 1'b1, 12'h048, 32'd12);
        ack_is("R3 masked on cpu0", 0, NONE);
        wr(0, 1'b0, 12'h130, 32'd2);
        ack_is("R3 cpu1 unaffected", 1, 10'd12);
        wr(0, 1'b1, 12'h04C, 32'd12);
        wr(0, 1'b0, 12'h130, 32'd1);
        ack_is("R3 unmasked cpu0", 0, 10'd12);
        ack_is("R3 cpu1 after reroute", 1, NONE);

        // R4 multi-processor route
        lines(32'h0001_0000, 4'h0);
        wr(0, 1'b0, 12'h140, 32'd3);
        ack_is("R4 multi cpu0", 0, 10'd16);
        ack_is("R4 multi cpu1", 1, 10'd16);
        ack_is("R4 multi cpu2", 2, NONE);

        // R9 level behaviour
        lines(32'h0010_0000, 4'h0);
        ack_is("R9 first read", 0, 10'd20);
        ack_is("R9 second read", 0, 10'd20);
        lines(32'h0, 4'h0);
        ack_is("R9 line dropped", 0, NONE);
        chk("R9 irq dropped", 32'(irq_o), 32'd0);

        finish_run();
    end
endmodule